// File: doc/BRIEF.md
# LPC Memory-Cycle Target

This block is the target side of a Low Pin Count bus for memory read and write cycles. It watches a 4-bit multiplexed nibble bus and an active-low frame strobe, both sampled on the rising edge of the bus clock. It recognises the start nibble and checks the cycle-type nibble. It then assembles a 32-bit address from eight nibbles and decides whether the address belongs to it. For a read it fetches one byte from a backing memory port and returns it in two nibbles. For a write it collects two data nibbles and issues a write strobe. In both cases it drives the turnaround and sync nibbles that the protocol expects.

A 4-bit strap selects which 4 MB memory window and which 4 MB register window the target answers. The target with strap 0 also answers a 128 KB boot alias below the 1 MB line. The pad is modelled as a value output and a registered output enable. Outside the cycles in which the target owns the bus, the enable is low and the pad is high-impedance.

Top module: `lpc_mem_target`

## Requirements
- R1: A cycle begins on an edge where frame_ni is low and lad_i is 0000. While frame_ni stays low with further 0000 nibbles, the cycle restarts each time. The cycle-type nibble is the one sampled on the first edge with frame_ni high. Clock 1 of a cycle is the last start clock.
- R2: The cycle-type nibble must have bits [3:2] = 01 for a memory cycle. Bit 1 selects the direction: 0 is a read and 1 is a write. Bit 0 is ignored. Any other type produces no memory strobe and leaves the bus released.
- R3: The address arrives in clocks 3 to 10, one nibble per clock, most significant nibble first. While a memory strobe is high, mem_addr_o carries the low 22 bits of the address as a window offset.
- R4: For a read, mem_rd_o is high in clock 11 only, and mem_rdata_i is taken one clock later. The bus carries 1111 in clock 12, 0000 in clock 13, data[3:0] in clock 14, data[7:4] in clock 15 and 1111 in clock 16. It is released from clock 17.
- R5: For a write, data[3:0] is taken in clock 11 and data[7:4] in clock 12. mem_wr_o is high in clock 13 only, with the byte on mem_wdata_o. The bus carries 1111 in clock 14, 0000 in clock 15 and 1111 in clock 16. It is released from clock 17.
- R6: lad_oe_o is low in every clock not listed in R4 and R5.
- R7: Let g be strap_id_i[3:2]. The memory window is the 4 MB ending at FFFF_FFFF - g*0080_0000, and there mem_reg_o is 0. The register window is the 4 MB directly below it, and there mem_reg_o is 1.
- R8: With strap_id_i = 0, memory cycles to 000E_0000..000F_FFFF are also accepted, with offset 3E_0000 + (address - 000E_0000). With any other strap this range is not accepted.
- R9: An address outside every window gives no strobe and no bus drive. The target stays silent until the next start.
- R10: A low level on rst_ni or on init_ni asynchronously returns the target to idle and drops lad_oe_o at once, including in the middle of a read.
- R11: frame_ni low at any clock of a cycle aborts it. With lad_i = 0000 that clock is a new start; with any other nibble the target goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_ni | input | 1 | Second active-low reset, same effect |
| strap_id_i | input | 4 | Device ID strap |
| frame_ni | input | 1 | Active-low frame strobe |
| lad_i | input | 4 | Nibble bus as seen at the pad |
| lad_o | output | 4 | Nibble driven onto the pad |
| lad_oe_o | output | 1 | Pad output enable (registered) |
| mem_addr_o | output | 22 | Window offset for the backing memory |
| mem_reg_o | output | 1 | Access targets the register window |
| mem_rd_o | output | 1 | One-clock read strobe |
| mem_wr_o | output | 1 | One-clock write strobe |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid one clock after mem_rd_o |

## Verification
Reads and writes are run in both the memory and register windows under straps from three different groups. This separates a correct group offset from a fixed decode, and memory from register flagging. Boot-alias writes are read back through the high address, which confirms that both reach the same offset. The same range is then tried under a non-zero strap to confirm it is rejected. Non-memory cycle types, a set reserved bit and repeated start nibbles show that type checking ignores only bit 0 and that the last start wins. Mid-address frame assertions, with and without a start nibble, and an init pulse during the data nibbles separate restart, abort and reset.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR,
    ST_RTAR0, ST_RTAR1, ST_RSYNC, ST_RDLO, ST_RDHI, ST_RTARE,
    ST_WDLO, ST_WDHI, ST_WTAR0, ST_WTAR1, ST_WSYNC, ST_WTARE
  } lpc_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_SYNC  = 4'h0;
  localparam logic [3:0] NIB_TAR   = 4'hF;
  localparam logic [1:0] CT_MEM    = 2'b01;

  function automatic logic owns_bus(lpc_state_e s);
    return s inside {ST_RTAR1, ST_RSYNC, ST_RDLO, ST_RDHI, ST_RTARE,
                     ST_WTAR1, ST_WSYNC, ST_WTARE};
  endfunction

endpackage

// File: rtl/lpc_addr_decode.sv
module lpc_addr_decode #(
  parameter int ADDR_W  = 32,
  parameter int WIN_AW  = 22,
  parameter int ID_W    = 4,
  parameter int BOOT_AW = 17,
  parameter int LOW_AW  = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ID_W-1:0]   strap_i,
  output logic              hit_o,
  output logic              reg_o,
  output logic [WIN_AW-1:0] off_o
);
  localparam int TAG_W  = ADDR_W - WIN_AW;
  localparam int GRP_W  = ID_W - 2;
  localparam int BTAG_W = ADDR_W - BOOT_AW;
  localparam logic [BTAG_W-1:0] BOOT_TAG = BTAG_W'((1 << (LOW_AW - BOOT_AW)) - 1);

  logic [GRP_W-1:0] grp;
  logic [TAG_W-1:0] mem_tag, reg_tag;
  logic mem_hit, reg_hit, boot_hit;

  assign grp     = strap_i[ID_W-1:2];
  // each group of four straps sits two 4 MB windows lower
  assign mem_tag = {TAG_W{1'b1}} - TAG_W'({grp, 1'b0});
  assign reg_tag = mem_tag - TAG_W'(1);

  assign mem_hit  = addr_i[ADDR_W-1:WIN_AW] == mem_tag;
  assign reg_hit  = addr_i[ADDR_W-1:WIN_AW] == reg_tag;
  assign boot_hit = (strap_i == '0) && (addr_i[ADDR_W-1:BOOT_AW] == BOOT_TAG);

  always_comb begin
    hit_o = mem_hit | reg_hit | boot_hit;
    reg_o = reg_hit;
    off_o = boot_hit ? {{(WIN_AW-BOOT_AW){1'b1}}, addr_i[BOOT_AW-1:0]}
                     : addr_i[WIN_AW-1:0];
  end

endmodule

// File: rtl/lpc_seq_fsm.sv
module lpc_seq_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_AW = 22,
  parameter int ID_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        lad_i,
  input  logic [ID_W-1:0]   strap_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output lpc_state_e        state_d_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [WIN_AW-1:0] mem_addr_o,
  output logic              mem_reg_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int NIB_N = ADDR_W / 4;
  localparam int CNT_W = $clog2(NIB_N);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NIB_N - 1);

  lpc_state_e state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-5:0] addr_q;
  logic [ADDR_W-1:0] addr_full;
  logic              dir_wr_q;
  logic              dec_hit, dec_reg;
  logic [WIN_AW-1:0] dec_off;
  logic              addr_done;

  assign addr_full = {addr_q, lad_i};
  assign addr_done = (state_q == ST_ADDR) && (cnt_q == CNT_LAST);

  lpc_addr_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .ID_W(ID_W)) u_dec (
    .addr_i (addr_full),
    .strap_i(strap_i),
    .hit_o  (dec_hit),
    .reg_o  (dec_reg),
    .off_o  (dec_off)
  );

  always_comb begin
    state_d = state_q;
    if (!frame_ni) begin
      // frame always wins: restart on a start nibble, else abort
      state_d = (lad_i == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_CTYPE: state_d = (lad_i[3:2] == CT_MEM) ? ST_ADDR : ST_IDLE;
        ST_ADDR:  if (cnt_q == CNT_LAST)
                    state_d = !dec_hit ? ST_IDLE : (dir_wr_q ? ST_WDLO : ST_RTAR0);
        ST_RTAR0: state_d = ST_RTAR1;
        ST_RTAR1: state_d = ST_RSYNC;
        ST_RSYNC: state_d = ST_RDLO;
        ST_RDLO:  state_d = ST_RDHI;
        ST_RDHI:  state_d = ST_RTARE;
        ST_RTARE: state_d = ST_IDLE;
        ST_WDLO:  state_d = ST_WDHI;
        ST_WDHI:  state_d = ST_WTAR0;
        ST_WTAR0: state_d = ST_WTAR1;
        ST_WTAR1: state_d = ST_WSYNC;
        ST_WSYNC: state_d = ST_WTARE;
        ST_WTARE: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      dir_wr_q    <= 1'b0;
      mem_addr_o  <= '0;
      mem_reg_o   <= 1'b0;
      mem_wdata_o <= '0;
      rdata_o     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CTYPE) begin
        dir_wr_q <= lad_i[1];
        cnt_q    <= '0;
      end
      if (state_q == ST_ADDR) begin
        addr_q <= addr_full[ADDR_W-5:0];
        cnt_q  <= cnt_q + CNT_W'(1);
      end
      if (addr_done && dec_hit) begin
        mem_addr_o <= dec_off;
        mem_reg_o  <= dec_reg;
      end
      if (state_q == ST_WDLO) mem_wdata_o[3:0] <= lad_i;
      if (state_q == ST_WDHI) mem_wdata_o[DATA_W-1:4] <= lad_i;
      if (state_q == ST_RTAR1) rdata_o <= mem_rdata_i;
    end
  end

  assign mem_rd_o  = (state_q == ST_RTAR0);
  assign mem_wr_o  = (state_q == ST_WTAR0);
  assign state_d_o = state_d;

  // R4: read strobe lasts one clock
  a_r4_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  // R5: write strobe lasts one clock
  a_r5_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);
  // R11: frame with a non-start nibble aborts to idle
  a_r11_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_ni && lad_i != NIB_START) |=> (state_q == ST_IDLE && !mem_rd_o && !mem_wr_o));

endmodule

// File: rtl/lpc_bus_drv.sv
module lpc_bus_drv
  import lpc_tgt_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DRIVE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lpc_state_e        state_d_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o
);
  localparam int RUN_W = $clog2(MAX_DRIVE + 1) + 1;

  logic [3:0] lad_d;

  always_comb begin
    unique case (state_d_i)
      ST_RSYNC, ST_WSYNC: lad_d = NIB_SYNC;
      ST_RDLO:            lad_d = rdata_i[3:0];
      ST_RDHI:            lad_d = rdata_i[DATA_W-1:4];
      default:            lad_d = NIB_TAR;
    endcase
  end

  // outputs for clock k are registered from the state chosen for clock k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lad_o    <= NIB_TAR;
      lad_oe_o <= 1'b0;
    end else begin
      lad_o    <= lad_d;
      lad_oe_o <= owns_bus(state_d_i);
    end
  end

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (lad_oe_o) run_q <= run_q + RUN_W'(1);
    else               run_q <= '0;
  end

  // R6: target never holds the bus longer than a read's drive window
  a_r6_drive_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lad_oe_o |-> (run_q < RUN_W'(MAX_DRIVE)));

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_AW = 22,
  parameter int ID_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_ni,
  input  logic [ID_W-1:0]   strap_id_i,
  input  logic              frame_ni,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic [WIN_AW-1:0] mem_addr_o,
  output logic              mem_reg_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic       rst_n;
  lpc_state_e state_d;
  logic [DATA_W-1:0] rdata;

  assign rst_n = rst_ni & init_ni;

  lpc_seq_fsm #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .ID_W(ID_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .frame_ni   (frame_ni),
    .lad_i      (lad_i),
    .strap_i    (strap_id_i),
    .mem_rdata_i(mem_rdata_i),
    .state_d_o  (state_d),
    .rdata_o    (rdata),
    .mem_addr_o (mem_addr_o),
    .mem_reg_o  (mem_reg_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  lpc_bus_drv #(.DATA_W(DATA_W)) u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .state_d_i(state_d),
    .rdata_i  (rdata),
    .lad_o    (lad_o),
    .lad_oe_o (lad_oe_o)
  );

  // R4: turnaround ones follow the read strobe
  a_r4_tar_after_rd: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_rd_o && frame_ni) |=> (lad_oe_o && lad_o == NIB_TAR));
  // R5: bus stays released while the write strobe is high, ones follow
  a_r5_tar_after_wr: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_wr_o |-> !lad_oe_o);
  a_r5_drive_after_wr: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_wr_o && frame_ni) |=> (lad_oe_o && lad_o == NIB_TAR));

endmodule

// File: tb/sim_lpc_mem_target.sv
module sim_lpc_mem_target;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni, init_ni, frame_ni;
  logic [3:0]  strap, lad_in, lad_o;
  logic        lad_oe_o, mem_reg_o, mem_rd_o, mem_wr_o;
  logic [21:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata;

  lpc_mem_target u0 (
    .clk_i(clk), .rst_ni(rst_ni), .init_ni(init_ni), .strap_id_i(strap),
    .frame_ni(frame_ni), .lad_i(lad_in), .lad_o(lad_o), .lad_oe_o(lad_oe_o),
    .mem_addr_o(mem_addr_o), .mem_reg_o(mem_reg_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural backing store
  bit [7:0] store [int];
  function automatic bit [7:0] bm_get(int key);
    if (store.exists(key)) return store[key];
    return 8'(key * 37 + 11);
  endfunction
  function automatic int mkkey(bit rg, bit [21:0] off);
    return int'({rg, off});
  endfunction

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata <= bm_get(mkkey(mem_reg_o, mem_addr_o));
    if (mem_wr_o) store[mkkey(mem_reg_o, mem_addr_o)] = mem_wdata_o;
  end

  typedef struct packed { bit frame; bit [3:0] lad; } drv_t;
  typedef struct packed {
    bit oe; bit [3:0] lad; bit rd; bit wr; bit chk; bit [21:0] off; bit rg; bit [7:0] wd;
  } exp_t;

  drv_t  in_q[$];
  exp_t  exp_q[$];
  string tag_q[$];

  function automatic drv_t mkd(bit f, bit [3:0] l);
    drv_t d; d.frame = f; d.lad = l; return d;
  endfunction

  function automatic void push_exp(bit oe, bit [3:0] l, bit rd, bit wr, bit chk,
                                   bit [21:0] off, bit rg, bit [7:0] wd, string t);
    exp_t e;
    e.oe = oe; e.lad = l; e.rd = rd; e.wr = wr; e.chk = chk;
    e.off = off; e.rg = rg; e.wd = wd;
    exp_q.push_back(e); tag_q.push_back(t);
  endfunction

  function automatic void push_idle(int n, string t);
    for (int i = 0; i < n; i++) push_exp(0, 4'h0, 0, 0, 0, '0, 0, 8'h0, t);
  endfunction

  // window model written from the requirement text
  function automatic void model_map(input bit [31:0] a, input bit [3:0] s,
                                    output bit hit, output bit rg, output bit [21:0] off);
    longint top, lo_m, lo_r;
    top  = 64'hFFFF_FFFF - longint'(s / 4) * 64'h0080_0000;
    lo_m = top - 64'h003F_FFFF;
    lo_r = lo_m - 64'h0040_0000;
    hit = 0; rg = 0; off = '0;
    if (longint'(a) >= lo_m && longint'(a) <= top) begin
      hit = 1; off = 22'(longint'(a) - lo_m);
    end else if (longint'(a) >= lo_r && longint'(a) < lo_m) begin
      hit = 1; rg = 1; off = 22'(longint'(a) - lo_r);
    end else if (s == 0 && a >= 32'h000E_0000 && a <= 32'h000F_FFFF) begin
      hit = 1; off = 22'(a - 32'h000E_0000 + 32'h003E_0000);
    end
  endfunction

  task automatic push_cycle(bit [3:0] ct, bit [31:0] a, bit [7:0] d, int pre, string t);
    bit hit, rg, wr, act;
    bit [21:0] off;
    bit [7:0] rb;
    model_map(a, strap, hit, rg, off);
    wr  = ct[1];
    act = (ct[3:2] == 2'b01) && hit;
    rb  = bm_get(mkkey(rg, off));
    for (int i = 0; i < pre; i++) begin in_q.push_back(mkd(0, 4'h0)); push_idle(1, t); end
    in_q.push_back(mkd(0, 4'h0));
    in_q.push_back(mkd(1, ct));
    for (int i = 7; i >= 0; i--) in_q.push_back(mkd(1, a[4*i +: 4]));
    in_q.push_back(mkd(1, wr ? d[3:0] : 4'hF));
    in_q.push_back(mkd(1, wr ? d[7:4] : 4'hF));
    for (int i = 0; i < 5; i++) in_q.push_back(mkd(1, 4'hF));
    push_idle(10, t);
    if (act && !wr) begin
      push_exp(0, 4'h0, 1, 0, 1, off, rg, 8'h0, t);    // 11
      push_exp(1, 4'hF, 0, 0, 0, '0, 0, 8'h0, t);      // 12
      push_exp(1, 4'h0, 0, 0, 0, '0, 0, 8'h0, t);      // 13
      push_exp(1, rb[3:0], 0, 0, 0, '0, 0, 8'h0, t);   // 14
      push_exp(1, rb[7:4], 0, 0, 0, '0, 0, 8'h0, t);   // 15
      push_exp(1, 4'hF, 0, 0, 0, '0, 0, 8'h0, t);      // 16
      push_idle(1, t);                                  // 17
    end else if (act && wr) begin
      push_idle(2, t);                                  // 11,12
      push_exp(0, 4'h0, 0, 1, 1, off, rg, d, t);       // 13
      push_exp(1, 4'hF, 0, 0, 0, '0, 0, 8'h0, t);      // 14
      push_exp(1, 4'h0, 0, 0, 0, '0, 0, 8'h0, t);      // 15
      push_exp(1, 4'hF, 0, 0, 0, '0, 0, 8'h0, t);      // 16
      push_idle(1, t);                                  // 17
    end else begin
      push_idle(7, t);
    end
  endtask

  task automatic step();
    exp_t e; string t; drv_t d; bit bad;
    @(negedge clk);
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
    else begin e = '0; t = "R6 idle"; end
    bad = (lad_oe_o !== e.oe) || (e.oe && lad_o !== e.lad) ||
          (mem_rd_o !== e.rd) || (mem_wr_o !== e.wr) ||
          (e.chk && (mem_addr_o !== e.off || mem_reg_o !== e.rg)) ||
          (e.chk && e.wr && mem_wdata_o !== e.wd);
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got oe=%b lad=%h rd=%b wr=%b addr=%h reg=%b wd=%h exp oe=%b lad=%h rd=%b wr=%b addr=%h reg=%b wd=%h",
               t, lad_oe_o, lad_o, mem_rd_o, mem_wr_o, mem_addr_o, mem_reg_o, mem_wdata_o,
               e.oe, e.lad, e.rd, e.wr, e.off, e.rg, e.wd);
    end
    d = (in_q.size() > 0) ? in_q.pop_front() : mkd(1, 4'hF);
    frame_ni = d.frame; lad_in = d.lad;
  endtask

  task automatic run_all();
    while (in_q.size() > 0 || exp_q.size() > 0) step();
    step(); step();
  endtask

  task automatic check1(bit ok, string t, string got, string exp);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s: got %s expected %s", t, got, exp); end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 0; init_ni = 1; frame_ni = 1; lad_in = 4'hF; strap = 4'd0;
    repeat (3) @(negedge clk);
    check1(!lad_oe_o && !mem_rd_o && !mem_wr_o, "R10 reset state",
           $sformatf("oe=%b rd=%b wr=%b", lad_oe_o, mem_rd_o, mem_wr_o), "all 0");
    rst_ni = 1;
    step();

    // strap 0: main read/write, R3 R4 R5 R7
    push_cycle(4'b0100, 32'hFFFF_FFF0, 8'h00, 0, "R3 R4 read top"); run_all();
    push_cycle(4'b0110, 32'hFFC0_1234, 8'hA5, 0, "R5 write");        run_all();
    push_cycle(4'b0100, 32'hFFC0_1234, 8'h00, 0, "R4 readback");     run_all();
    push_cycle(4'b0100, 32'hFF80_0042, 8'h00, 0, "R7 reg window");   run_all();
    // boot alias R8
    push_cycle(4'b0110, 32'h000E_0001, 8'h3C, 0, "R8 alias write");  run_all();
    push_cycle(4'b0100, 32'hFFFE_0001, 8'h00, 0, "R8 alias readback high"); run_all();
    push_cycle(4'b0100, 32'h000F_FFF0, 8'h00, 0, "R8 alias read");   run_all();
    push_cycle(4'b0100, 32'h0010_0000, 8'h00, 0, "R9 miss above alias"); run_all();
    // cycle type R2
    push_cycle(4'b0000, 32'hFFFF_FFF0, 8'h00, 0, "R2 io type ignored");  run_all();
    push_cycle(4'b1010, 32'hFFFF_FFF0, 8'h5A, 0, "R2 bad type write");   run_all();
    push_cycle(4'b0101, 32'hFFFF_0007, 8'h00, 0, "R2 bit0 ignored");     run_all();
    // repeated starts R1
    push_cycle(4'b0100, 32'hFFD0_0010, 8'h00, 2, "R1 last start");       run_all();
    push_cycle(4'b0110, 32'hFFD0_0010, 8'hC3, 3, "R1 last start write"); run_all();

    // strap 5 (group 1) R7 R8 R9
    strap = 4'd5; step();
    push_cycle(4'b0100, 32'hFF40_0100, 8'h00, 0, "R7 group1 mem");    run_all();
    push_cycle(4'b0110, 32'hFF3F_FFFF, 8'h96, 0, "R7 group1 reg wr"); run_all();
    push_cycle(4'b0100, 32'hFF3F_FFFF, 8'h00, 0, "R7 group1 reg rd"); run_all();
    push_cycle(4'b0100, 32'hFFC0_0000, 8'h00, 0, "R9 other group");   run_all();
    push_cycle(4'b0100, 32'h000F_0000, 8'h00, 0, "R8 no alias strap5"); run_all();

    // strap 13 (group 3)
    strap = 4'd13; step();
    push_cycle(4'b0100, 32'hFE7F_FFFE, 8'h00, 0, "R7 group3 mem");   run_all();
    push_cycle(4'b0100, 32'hFE00_0000, 8'h00, 0, "R7 group3 reg");   run_all();
    push_cycle(4'b0110, 32'hFDFF_FFFF, 8'h11, 0, "R9 below group3"); run_all();

    // R11 restart and abort
    strap = 4'd0; step();
    in_q.push_back(mkd(0, 4'h0)); in_q.push_back(mkd(1, 4'h4));
    for (int i = 0; i < 3; i++) in_q.push_back(mkd(1, 4'hF));
    push_idle(5, "R11 restart");
    push_cycle(4'b0100, 32'hFFE0_0ABC, 8'h00, 0, "R11 restart read"); run_all();
    in_q.push_back(mkd(0, 4'h0)); in_q.push_back(mkd(1, 4'h4));
    in_q.push_back(mkd(1, 4'hF)); in_q.push_back(mkd(1, 4'hF));
    in_q.push_back(mkd(0, 4'hF));
    for (int i = 0; i < 12; i++) in_q.push_back(mkd(1, 4'hF));
    push_idle(17, "R11 abort");
    run_all();

    // R10 init in the middle of a read
    push_cycle(4'b0100, 32'hFFFF_0100, 8'h00, 0, "R10 pre-reset read");
    for (int i = 0; i < 14; i++) step();
    check1(lad_oe_o, "R4 driving before init", $sformatf("oe=%b", lad_oe_o), "oe=1");
    #2 init_ni = 0;
    #1 check1(!lad_oe_o, "R10 init releases bus", $sformatf("oe=%b", lad_oe_o), "oe=0");
    in_q.delete(); exp_q.delete(); tag_q.delete();
    frame_ni = 1; lad_in = 4'hF;
    @(negedge clk);
    check1(!lad_oe_o && !mem_rd_o, "R10 held idle", $sformatf("oe=%b rd=%b", lad_oe_o, mem_rd_o), "0 0");
    init_ni = 1;
    step(); step();
    push_cycle(4'b0100, 32'hFFFF_0100, 8'h00, 0, "R10 read after init"); run_all();

    summary();
    $finish;
  end

endmodule